// File: doc/BRIEF.md
# Programmable Threshold Event Counter Bank

This block holds a small bank of event counters. Each counter has its own 64-bit event-select register. The register picks one source bus out of several and a subset of that bus's lanes. In each clock cycle the number of chosen lanes that are asserted forms a per-cycle event count. Depending on the select register, the counter either adds that count, or adds one per cycle in which the count passes a programmable threshold. The threshold test can be inverted, and an edge mode reduces it to one increment each time the condition becomes true.

Counting is qualified by a local enable bit and by two privilege bits, one for user mode and one for kernel mode. These are compared against a privilege input sampled every cycle. When a counter wraps, a one-cycle overflow flag is raised for it. If that counter's interrupt bit is set, an interrupt request is raised as well. Software sets up the select registers and reads or preloads the counters through a simple synchronous register port.

Top module: `evc_bank`

## Requirements
- R1: After a synchronous reset every counter, every select register, `ovf` and `irq` read as zero.
- R2: `reg_addr` with MSB 0 addresses the select register of counter `reg_addr[IDX_W-1:0]`, and MSB 1 addresses its counter value. `reg_rdata` is registered and shows the addressed register one cycle after the address is presented. A select register keeps the low 32 bits of a write and reads zero in bits 63:32. Counter values are zero-extended.
- R3: Select bits [7:0] choose source bus `code`. A code of NUM_SRC or more selects nothing. Select bits [8+LANES-1:8] mask the lanes of that source, and the per-cycle count is the number of lanes that are both set and unmasked.
- R4: While select bit 22 (enable) is 0, the counter does not change unless it is written.
- R5: Select bit 16 allows counting while `priv_user` is 1, and bit 17 allows counting while `priv_user` is 0. With both set the counter counts in either mode, and with neither it never counts.
- R6: With counter mask bits [31:24] equal to 0, the counter adds the full per-cycle count, and bit 23 (invert) has no effect.
- R7: With a nonzero mask M and invert clear, the counter adds 1 in each cycle whose count is at least M.
- R8: With a nonzero mask M and invert set, the counter adds 1 in each cycle whose count is below M.
- R9: With bit 18 (edge) set and M nonzero, the counter adds 1 only in a cycle where the threshold condition holds and did not hold in the previous cycle. The condition is tracked every cycle, whether or not counting is allowed.
- R10: When a counter wraps past its maximum, its `ovf` bit is 1 for the following cycle only. `irq` is 1 in that same cycle if bit 20 of that counter's select register is set.
- R11: A write to a counter value takes precedence over any increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address: MSB selects counter value (1) or select register (0) |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Registered read data for `reg_addr` |
| priv_user | input | 1 | 1 while the core runs in user mode, 0 in kernel mode |
| evt_bus | input | NUM_SRC*LANES | Event lanes, source s at bits [s*LANES +: LANES] |
| ovf | output | NUM_CNT | Per-counter wrap flag, one cycle |
| irq | output | 1 | Interrupt request from any wrapping counter whose interrupt bit is set |

## Verification
A wrong threshold, invert or edge state shows up as a counter total that differs from the histogram of the driven pattern. That total can be read back two cycles after the last event. A stale edge history shows up as an extra or missing increment on the first cycle of a burst, so the edge cases start from a known idle condition. Wrong carry handling shows up at `ovf` and `irq` one cycle after the wrapping increment, and as a wrong residue in the counter.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int SEL_W = 32;

  typedef struct packed {
    logic [7:0] cmask;     // [31:24] threshold
    logic       inv;       // 23
    logic       en;        // 22
    logic       rsv21;     // 21 stored only
    logic       int_en;    // 20
    logic       rsv19;     // 19 stored only
    logic       edge_det;  // 18
    logic       os;        // 17
    logic       usr;       // 16
    logic [7:0] umask;     // [15:8]
    logic [7:0] code;      // [7:0]
  } evsel_t;
endpackage

// File: rtl/evc_event_mux.sv
module evc_event_mux #(
  parameter int NUM_SRC = 4,
  parameter int LANES   = 4,
  parameter int CW      = $clog2(LANES + 1)
) (
  input  logic [NUM_SRC*LANES-1:0] evt_bus,
  input  logic [7:0]               code,
  input  logic [LANES-1:0]         lane_mask,
  output logic [CW-1:0]            evt_cnt
);
  logic [LANES-1:0] lanes;

  always_comb begin
    lanes = '0;
    for (int s = 0; s < NUM_SRC; s++)
      if (code == 8'(s)) lanes = evt_bus[s*LANES +: LANES];
    lanes = lanes & lane_mask;
  end

  always_comb begin
    evt_cnt = '0;
    for (int l = 0; l < LANES; l++)
      evt_cnt = evt_cnt + CW'(lanes[l]);
  end
endmodule

// File: rtl/evc_qualify.sv
module evc_qualify #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] evt_cnt,
  input  logic [7:0]    cmask,
  input  logic          inv,
  input  logic          edge_det,
  input  logic          gate_ok,
  output logic [CW-1:0] inc
);
  logic [7:0] cnt8;
  logic       cond, prev_cond;
  logic       thr_mode;

  assign cnt8     = 8'(evt_cnt);
  assign thr_mode = (cmask != 8'd0);
  assign cond     = inv ? (cnt8 < cmask) : (cnt8 >= cmask);

  always_ff @(posedge clk) begin
    if (rst) prev_cond <= 1'b0;
    else     prev_cond <= cond;
  end

  always_comb begin
    if (!gate_ok)          inc = '0;
    else if (!thr_mode)    inc = evt_cnt;
    else if (edge_det)     inc = CW'(cond & ~prev_cond);
    else                   inc = CW'(cond);
  end

  // R7
  thresh_unit_chk: assert property (@(posedge clk) disable iff (rst)
    thr_mode |-> inc <= CW'(1));

  // R9
  edge_single_chk: assert property (@(posedge clk) disable iff (rst)
    (thr_mode && edge_det && $past(thr_mode && edge_det && inc != '0)) |-> inc == '0);
endmodule

// File: rtl/evc_accum.sv
module evc_accum #(
  parameter int CNT_W = 48,
  parameter int CW    = 3,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    inc,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             int_en,
  output logic [CNT_W-1:0] count_q,
  output logic             ovf_q,
  output logic             irq_q
);
  logic [CNT_W:0] sum;
  assign sum = {1'b0, count_q} + (CNT_W+1)'(inc);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else if (wr) begin
      count_q <= wdata;
      ovf_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      count_q <= sum[CNT_W-1:0];
      ovf_q   <= sum[CNT_W];
      irq_q   <= sum[CNT_W] & int_en;
    end
  end

  // R10
  wrap_residue_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> count_q < CNT_W'(LANES));

  // R10
  irq_needs_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ovf_q);

  // R11
  wr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> count_q == $past(wdata));
endmodule

// File: rtl/evc_bank.sv
module evc_bank
  import evc_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 48,
  parameter int NUM_SRC = 4,
  parameter int LANES   = 4,
  parameter int IDX_W   = $clog2(NUM_CNT),
  parameter int ADDR_W  = IDX_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_wr,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [63:0]              reg_wdata,
  output logic [63:0]              reg_rdata,
  input  logic                     priv_user,
  input  logic [NUM_SRC*LANES-1:0] evt_bus,
  output logic [NUM_CNT-1:0]       ovf,
  output logic                     irq
);
  localparam int CW = $clog2(LANES + 1);

  logic [SEL_W-1:0] sel_q   [NUM_CNT];
  logic [CNT_W-1:0] count   [NUM_CNT];
  logic [NUM_CNT-1:0] irq_v;
  logic [IDX_W-1:0] idx;
  logic             to_cnt;

  assign idx    = reg_addr[IDX_W-1:0];
  assign to_cnt = reg_addr[ADDR_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CNT; i++) sel_q[i] <= '0;
    end else if (reg_wr && !to_cnt) begin
      sel_q[idx] <= reg_wdata[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (to_cnt) reg_rdata <= 64'(count[idx]);
    else             reg_rdata <= 64'(sel_q[idx]);
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    evsel_t        s;
    logic [CW-1:0] evt_cnt, inc;
    logic          gate_ok, wr_here;

    assign s       = evsel_t'(sel_q[g]);
    assign gate_ok = s.en & ((s.usr & priv_user) | (s.os & ~priv_user));
    assign wr_here = reg_wr & to_cnt & (idx == IDX_W'(g));

    evc_event_mux #(.NUM_SRC(NUM_SRC), .LANES(LANES), .CW(CW)) i_mux (
      .evt_bus(evt_bus), .code(s.code), .lane_mask(s.umask[LANES-1:0]),
      .evt_cnt(evt_cnt));

    evc_qualify #(.CW(CW)) i_qual (
      .clk(clk), .rst(rst), .evt_cnt(evt_cnt), .cmask(s.cmask), .inv(s.inv),
      .edge_det(s.edge_det), .gate_ok(gate_ok), .inc(inc));

    evc_accum #(.CNT_W(CNT_W), .CW(CW), .LANES(LANES)) i_acc (
      .clk(clk), .rst(rst), .inc(inc), .wr(wr_here),
      .wdata(reg_wdata[CNT_W-1:0]), .int_en(s.int_en),
      .count_q(count[g]), .ovf_q(ovf[g]), .irq_q(irq_v[g]));

    // R4
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!s.en && !wr_here) |=> $stable(count[g]));
  end

  assign irq = |irq_v;

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ovf != '0));

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;
endmodule

// File: tb/test_evc_bank.sv
`timescale 1ns/1ps
module test_evc_bank;
  localparam int NUM_CNT = 4, CNT_W = 48, NUM_SRC = 4, LANES = 4, ADDR_W = 3;

  logic clk = 1'b0, rst = 1'b1, reg_wr = 1'b0, priv_user = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic [NUM_SRC*LANES-1:0] evt_bus = '0;
  logic [NUM_CNT-1:0] ovf;
  logic irq;
  int total = 0, failed = 0;

  always #4 clk = ~clk;

  evc_bank #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .NUM_SRC(NUM_SRC), .LANES(LANES)) i_evc_bank (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .priv_user(priv_user), .evt_bus(evt_bus), .ovf(ovf), .irq(irq));

  // rows: {cmask[19:12], inv[11], edge[10], expected[9:0]}
  localparam logic [19:0] TBL [14] = '{
    {8'd0,1'b0,1'b0,10'd20}, {8'd0,1'b1,1'b0,10'd20},
    {8'd1,1'b0,1'b0,10'd8},  {8'd1,1'b1,1'b0,10'd2},
    {8'd2,1'b0,1'b0,10'd6},  {8'd2,1'b1,1'b0,10'd4},
    {8'd3,1'b0,1'b0,10'd4},  {8'd3,1'b1,1'b0,10'd6},
    {8'd4,1'b0,1'b0,10'd2},  {8'd4,1'b1,1'b0,10'd8},
    {8'd5,1'b0,1'b0,10'd0},  {8'd5,1'b1,1'b0,10'd10},
    {8'd3,1'b0,1'b1,10'd2},  {8'd3,1'b1,1'b1,10'd1}};
  localparam int PAT [10] = '{0,1,2,3,4,3,2,1,0,4};

  function automatic logic [63:0] mksel(int code, int umask, bit usr, bit os, bit edg,
                                        bit ien, bit en, bit inv, int cmask);
    return 64'({8'(cmask), inv, en, 1'b0, ien, 1'b0, edg, os, usr, 8'(umask), 8'(code)});
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [63:0] d);
    reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [63:0] d);
    reg_addr = ADDR_W'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(int n);
    evt_bus = '0; priv_user = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(int src, logic [3:0] lanes, bit pu, int n);
    evt_bus = '0; evt_bus[src*LANES +: LANES] = lanes; priv_user = pu;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - failed, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 ovf", 64'(ovf), 0);
    check("R1 irq", 64'(irq), 0);
    for (int i = 0; i < NUM_CNT; i++) begin
      rd(i, d);     check("R1 select", d, 0);
      rd(4 + i, d); check("R1 counter", d, 0);
    end

    // Table walk: pattern histogram 0..4 twice each, sum 20
    for (int r = 0; r < 14; r++) begin
      int c = r % NUM_CNT;
      string tag;
      tag = TBL[r][10] ? "R9 edge" : (TBL[r][19:12] == 0 ? "R6 full add" :
            (TBL[r][11] ? "R8 below mask" : "R7 at least mask"));
      wr(4 + c, 0);
      wr(c, mksel(0, 'hF, 1, 0, TBL[r][10], 0, 1, TBL[r][11], int'(TBL[r][19:12])));
      idle(1);
      for (int k = 0; k < 10; k++) drive(0, 4'((1 << PAT[k]) - 1), 1'b1, 1);
      idle(1);
      rd(4 + c, d);
      check(tag, d, 64'(TBL[r][9:0]));
    end

    // R2 select readback with upper bits dropped, counter preload readback
    wr(1, 64'hFFFF_FFFF_1234_5678);
    rd(1, d); check("R2 select readback", d, 64'h0000_0000_1234_5678);
    wr(6, 64'h1234);
    rd(6, d); check("R2 counter readback", d, 64'h1234);

    // R3 source 2, lane mask 0101, lanes 0111 -> 2 per cycle
    wr(4, 0); wr(0, mksel(2, 'h5, 1, 0, 0, 0, 1, 0, 0));
    drive(2, 4'b0111, 1'b1, 3); idle(1);
    rd(4, d); check("R3 source and lane mask", d, 6);
    // R3 out-of-range code counts nothing
    wr(4, 0); wr(0, mksel(7, 'hF, 1, 1, 0, 0, 1, 0, 0));
    drive(3, 4'hF, 1'b1, 3); idle(1);
    rd(4, d); check("R3 code beyond sources", d, 0);

    // R4 enable clear
    wr(5, 0); wr(1, mksel(0, 'hF, 1, 1, 0, 0, 0, 0, 0));
    drive(0, 4'hF, 1'b1, 3); drive(0, 4'hF, 1'b0, 2); idle(1);
    rd(5, d); check("R4 disabled", d, 0);

    // R5 privilege filtering
    wr(6, 0); wr(2, mksel(0, 'hF, 0, 1, 0, 0, 1, 0, 0));
    drive(0, 4'hF, 1'b1, 2); drive(0, 4'hF, 1'b0, 2); idle(1);
    rd(6, d); check("R5 kernel only", d, 8);
    wr(6, 0); wr(2, mksel(0, 'hF, 1, 0, 0, 0, 1, 0, 0));
    drive(0, 4'h7, 1'b0, 2); drive(0, 4'h7, 1'b1, 1); idle(1);
    rd(6, d); check("R5 user only", d, 3);
    wr(6, 0); wr(2, mksel(0, 'hF, 1, 1, 0, 0, 1, 0, 0));
    drive(0, 4'h7, 1'b1, 1); drive(0, 4'h7, 1'b0, 1); idle(1);
    rd(6, d); check("R5 both modes", d, 6);
    wr(6, 0); wr(2, mksel(0, 'hF, 0, 0, 0, 0, 1, 0, 0));
    drive(0, 4'h7, 1'b1, 1); drive(0, 4'h7, 1'b0, 1); idle(1);
    rd(6, d); check("R5 no mode", d, 0);

    // R11 write wins over a counting cycle
    wr(2, mksel(0, 'hF, 1, 0, 0, 0, 1, 0, 0));
    evt_bus = 16'h000F; priv_user = 1'b1;
    reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = 64'd100;
    @(negedge clk);
    reg_wr = 1'b0; idle(1);
    rd(6, d); check("R11 write precedence", d, 100);

    // R10 wrap with interrupt enabled
    wr(3, mksel(0, 'hF, 1, 0, 0, 1, 1, 0, 0));
    wr(7, 64'((64'd1 << CNT_W) - 2));
    drive(0, 4'h7, 1'b1, 1);
    check("R10 ovf after wrap", 64'(ovf), 64'b1000);
    check("R10 irq with int bit", 64'(irq), 1);
    idle(1);
    check("R10 ovf one cycle", 64'(ovf), 0);
    check("R10 irq one cycle", 64'(irq), 0);
    rd(7, d); check("R10 wrap residue", d, 1);
    // R10 wrap without interrupt bit
    wr(0, mksel(0, 'hF, 1, 0, 0, 0, 1, 0, 0));
    wr(4, 64'((64'd1 << CNT_W) - 1));
    drive(0, 4'h1, 1'b1, 1);
    check("R10 ovf no int", 64'(ovf), 64'b0001);
    check("R10 irq masked", 64'(irq), 0);
    idle(1);

    summary();
    $finish;
  end
endmodule